// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synchronous single-port memory whose data bus can switch between reads and writes on every clock cycle with no idle slot. A command (address, write strobe, chip enables, burst control) is captured on a rising clock edge. Read data appears from an output register one enabled edge later. Write data, with its per-lane selects, is taken one enabled edge after that. Because of this timing, read data and write data for commands of the same age share the same bus slot, and a read may follow a write directly, or a write follow a read.

Captured write data waits in a one-entry late-write holding register. It goes into the array when the next write's data arrives. A read that hits a write still in flight is answered from that write's data, merged lane by lane over the array contents. A load command can start a four-beat burst, and advance commands then step the low two address bits in either linear or interleaved order, chosen by a static mode input. A clock-enable input freezes the whole block. An output-enable indication marks the cycles in which the block drives read data.

Top module: `nbl_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After reset, `dout_oe` is 0 and no command is in flight.
- R2: A read that is accepted at enabled edge E drives `dout` with the stored word and sets `dout_oe` to 1 after enabled edge E+1. Both stay unchanged until the next enabled edge.
- R3: For a write that is accepted at enabled edge E, `din` and `lane_sel_n` are sampled at enabled edge E+2. Lane l is bits [9l+8:9l], and it is written only when `lane_sel_n[l]` is 0. Unselected lanes keep their contents.
- R4: Reads, writes and deselects may follow one another in any order, one per cycle. Every read returns the most recent data written to its address, counting writes still in flight.
- R5: While `clk_en_n` is 1 at an edge, no state changes. `dout` and `dout_oe` hold, and the command, data and select inputs of that edge are ignored.
- R6: A load cycle (`adv`=0) accepts a command only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination is a deselect: no write happens, and `dout_oe` is 0 for that slot.
- R7: `dout_oe` is 0 in every bus slot that carries write data.
- R8: A load starts a burst at address S. Up to three following `adv`=1 cycles repeat the load's command type at addresses whose upper bits equal those of S. Beat i has low bits (S+i) mod 4 when `burst_il`=0, and S xor i when `burst_il`=1. The chip enables are ignored on advance cycles.
- R9: An advance cycle with no burst in progress is a deselect. This covers an advance after reset, after a deselect load, and after the fourth beat.
- R10: A read issued one or two cycles after a write to the same address returns that write's selected lanes merged over the older contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 freezes the block |
| addr | input | AW | Command address |
| adv | input | 1 | 1 = advance the current burst, 0 = load a new command |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| burst_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_sel_n | input | LANES | Per-lane write selects, active low, sampled with write data |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | 1 when `dout` carries read data |

## Verification
The hardest case to reach from the ports is a read that must combine three sources in one cycle: data arriving on `din` at that very edge, the held write that has not yet been committed, and the array. Stalls that stretch the gaps make it harder still. The bench uses a 16-word configuration so that random traffic hits the same addresses constantly. It also runs directed sequences in which a full write and a partial write to one address are followed at once by reads, both one and two cycles later. Stall cycles are mixed into these sequences.

// File: rtl/nbl_pkg.sv
// Package: shared command encoding and burst address arithmetic.
// Assumes a fixed four-beat burst, so the beat index is two bits.
package nbl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int BEAT_BITS = 2;

    // Low address bits of beat idx for a burst that starts at start.
    function automatic logic [BEAT_BITS-1:0] beat_low(
        input logic [BEAT_BITS-1:0] start,
        input logic [BEAT_BITS-1:0] idx,
        input logic                 interleave
    );
        logic [BEAT_BITS-1:0] r;
        r = interleave ? (start ^ idx) : (start + idx);
        return r;
    endfunction

endpackage

// File: rtl/nbl_burst_seq.sv
// Command stage: decodes load/advance cycles and registers the resulting
// command (type and address) as pipeline stage one. It keeps the burst state.
// Assumes AW >= 3 and that the burst order input is static.
module nbl_burst_seq
    import nbl_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          load_sel,
    input  logic          adv,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic          interleave,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic          burst_live
);

    logic                 b_act;
    logic [BEAT_BITS-1:0] b_idx;
    logic [BEAT_BITS-1:0] nxt_idx;
    logic [AW-1:0]        b_base;
    logic                 b_wr;
    logic [AW-1:0]        beat_addr;

    // Next beat index and its address within the wrap window.
    always_comb begin
        nxt_idx   = b_idx + 2'd1;
        beat_addr = {b_base[AW-1:BEAT_BITS], beat_low(b_base[BEAT_BITS-1:0], nxt_idx, interleave)};
    end

    // Register the decoded command and update the burst tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            b_act  <= 1'b0;
            b_idx  <= '0;
            b_base <= '0;
            b_wr   <= 1'b0;
        end else if (!hold) begin
            if (!adv) begin
                if (load_sel) begin
                    op_q   <= wr_n ? OP_READ : OP_WRITE;
                    addr_q <= addr;
                    b_base <= addr;
                    b_idx  <= '0;
                    b_act  <= 1'b1;
                    b_wr   <= !wr_n;
                end else begin
                    op_q  <= OP_IDLE;
                    b_act <= 1'b0;
                end
            end else if (b_act) begin
                op_q   <= b_wr ? OP_WRITE : OP_READ;
                addr_q <= beat_addr;
                b_idx  <= nxt_idx;
                b_act  <= (nxt_idx != 2'd3);
            end else begin
                op_q <= OP_IDLE;
            end
        end
    end

    assign burst_live = b_act;

endmodule

// File: rtl/nbl_late_write.sv
// Storage with a one-entry late-write buffer. A write's data is held until
// the next write's data arrives and only then goes into the array. Reads
// are merged per lane from the incoming write, the held write and the array,
// with the incoming write taking highest priority.
// Assumes the incoming write data (wr_data) is valid at the edge where wr_go is high.
module nbl_late_write #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    wr_go,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_sel_n,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic             pend_v;
    logic [AW-1:0]    pend_addr;
    logic [DW-1:0]    pend_data;
    logic [LANES-1:0] pend_lanes;
    logic [DW-1:0]    mem_word;
    logic             hit_new;
    logic             hit_pend;

    // Commit the held write to the array when a new write arrives.
    always_ff @(posedge clk) begin
        if (rst_n && !hold && wr_go && pend_v) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_lanes[l]) begin
                    mem[pend_addr][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Capture the incoming write into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            pend_lanes <= '0;
        end else if (!hold && wr_go) begin
            pend_v     <= 1'b1;
            pend_addr  <= wr_addr;
            pend_data  <= wr_data;
            pend_lanes <= ~wr_sel_n;
        end
    end

    // Address comparison for the two forwarding sources.
    always_comb begin
        mem_word = mem[rd_addr];
        hit_new  = wr_go && (wr_addr == rd_addr);
        hit_pend = pend_v && (pend_addr == rd_addr);
    end

    // Per-lane merge, newest source first.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (hit_new && !wr_sel_n[g]) begin
                rd_data[g*LANE_W +: LANE_W] = wr_data[g*LANE_W +: LANE_W];
            end else if (hit_pend && pend_lanes[g]) begin
                rd_data[g*LANE_W +: LANE_W] = pend_data[g*LANE_W +: LANE_W];
            end else begin
                rd_data[g*LANE_W +: LANE_W] = mem_word[g*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/nbl_sram.sv
// Top level: the command stage feeds a second pipeline stage. A read
// loads the output register one enabled edge after it is accepted. A write
// takes its data one enabled edge after that. Clock enable freezes everything.
// Assumes a single clock domain and static burst_il.
module nbl_sram
    import nbl_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic [AW-1:0]           addr,
    input  logic                    adv,
    input  logic                    wr_n,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic                    burst_il,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);

    localparam int DW = LANES * LANE_W;

    op_e           p1_op;
    logic [AW-1:0] p1_addr;
    op_e           p2_op;
    logic [AW-1:0] p2_addr;
    logic          burst_live;
    logic          load_sel;
    logic [DW-1:0] rd_word;

    // All three chip enables must be asserted for a load to be accepted.
    assign load_sel = !cs_a_n && cs_b && !cs_c_n;

    nbl_burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (clk_en_n),
        .load_sel   (load_sel),
        .adv        (adv),
        .wr_n       (wr_n),
        .addr       (addr),
        .interleave (burst_il),
        .op_q       (p1_op),
        .addr_q     (p1_addr),
        .burst_live (burst_live)
    );

    nbl_late_write #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (clk_en_n),
        .wr_go    (p2_op == OP_WRITE),
        .wr_addr  (p2_addr),
        .wr_data  (din),
        .wr_sel_n (lane_sel_n),
        .rd_addr  (p1_addr),
        .rd_data  (rd_word)
    );

    // Second pipeline stage: age the command by one enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p2_op   <= OP_IDLE;
            p2_addr <= '0;
        end else if (!clk_en_n) begin
            p2_op   <= p1_op;
            p2_addr <= p1_addr;
        end
    end

    // Output register and drive indication for the read data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (!clk_en_n) begin
            dout_oe <= (p1_op == OP_READ);
            if (p1_op == OP_READ) begin
                dout <= rd_word;
            end
        end
    end

endmodule

// File: rtl/nbl_sram_chk.sv
// Checker: temporal properties of the pipeline, bound into nbl_sram.
// Assumes it observes the top level's own command stage signals.
module nbl_sram_chk
    import nbl_pkg::*;
#(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          adv,
    input logic          cs_a_n,
    input logic          cs_b,
    input logic          cs_c_n,
    input logic [DW-1:0] dout,
    input logic          dout_oe,
    input op_e           p1_op,
    input op_e           p2_op,
    input logic          burst_live
);

    // R1: reset leaves the bus undriven and no command in flight.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dout_oe && p1_op == OP_IDLE));

    // R2: an accepted read drives the bus after the next enabled edge.
    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && p1_op == OP_READ) |=> dout_oe);

    // R5: a stalled edge changes no output.
    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(dout) && $stable(dout_oe)));

    // R6: a load with the chip enables not all asserted is a deselect.
    a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv && !(!cs_a_n && cs_b && !cs_c_n)) |=> (p1_op == OP_IDLE));

    // R7: no drive while a write's data occupies the bus.
    a_r7_no_drive_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_op == OP_WRITE) |-> !dout_oe);

    // R9: an advance outside a burst issues nothing.
    a_r9_adv_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv && !burst_live) |=> (p1_op == OP_IDLE));

endmodule

bind nbl_sram nbl_sram_chk #(.DW(LANES * LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .adv        (adv),
    .cs_a_n     (cs_a_n),
    .cs_b       (cs_b),
    .cs_c_n     (cs_c_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .p1_op      (p1_op),
    .p2_op      (p2_op),
    .burst_live (burst_live)
);

// File: tb/nbl_sram_test.sv
// Bench: drives a 16-word configuration through directed sweeps and random
// traffic. It predicts every output from a reference array and from the
// timing stated in the requirements.
module nbl_sram_test;

    localparam int AW     = 4;
    localparam int LANES  = 4;
    localparam int LW     = 9;
    localparam int DW     = LANES * LW;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n;
    logic [AW-1:0] addr;
    logic          adv;
    logic          wr_n;
    logic          cs_a_n;
    logic          cs_b;
    logic          cs_c_n;
    logic          burst_il;
    logic [LANES-1:0] lane_sel_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_oe;

    always #10 clk = ~clk;

    nbl_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr), .adv(adv),
        .wr_n(wr_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .burst_il(burst_il), .lane_sel_n(lane_sel_n), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Reference model state.
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_op1 = 0;
    int            m_op2 = 0;
    logic [AW-1:0] m_a1 = '0;
    logic [AW-1:0] m_a2 = '0;
    logic          exp_oe = 1'b0;
    logic [DW-1:0] exp_dout = '0;
    logic          bm_act = 1'b0;
    logic [1:0]    bm_idx = '0;
    logic [AW-1:0] bm_base = '0;
    logic          bm_wr = 1'b0;

    task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Advance the model by one edge, using the values that were driven.
    task automatic model_edge();
        logic [1:0] low;
        if (!rst_n) begin
            m_op1 = 0; m_op2 = 0; exp_oe = 1'b0; exp_dout = '0; bm_act = 1'b0;
        end else if (!clk_en_n) begin
            if (m_op2 == 2) begin
                for (int l = 0; l < LANES; l++) begin
                    if (!lane_sel_n[l]) ref_mem[m_a2][l*LW +: LW] = din[l*LW +: LW];
                end
            end
            exp_oe = (m_op1 == 1);
            if (m_op1 == 1) exp_dout = ref_mem[m_a1];
            m_op2 = m_op1;
            m_a2  = m_a1;
            if (!adv) begin
                if (!cs_a_n && cs_b && !cs_c_n) begin
                    m_op1 = wr_n ? 1 : 2; m_a1 = addr;
                    bm_base = addr; bm_idx = 2'd0; bm_act = 1'b1; bm_wr = !wr_n;
                end else begin
                    m_op1 = 0; bm_act = 1'b0;
                end
            end else if (bm_act) begin
                bm_idx = bm_idx + 2'd1;
                low = burst_il ? (bm_base[1:0] ^ bm_idx) : (bm_base[1:0] + bm_idx);
                m_op1 = bm_wr ? 2 : 1;
                m_a1 = {bm_base[AW-1:2], low};
                bm_act = (bm_idx != 2'd3);
            end else begin
                m_op1 = 0;
            end
        end
    endtask

    // One cycle: drive, clock, predict, then check away from the edge.
    task automatic tick(input logic ce_n, input logic a_adv, input logic a_wr_n,
                        input logic [AW-1:0] a, input logic [2:0] cs,
                        input logic [DW-1:0] d, input logic [LANES-1:0] sel);
        clk_en_n = ce_n; adv = a_adv; wr_n = a_wr_n; addr = a;
        cs_a_n = cs[2]; cs_b = cs[1]; cs_c_n = cs[0];
        din = d; lane_sel_n = sel;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "dout_oe", {{(DW-1){1'b0}}, dout_oe}, {{(DW-1){1'b0}}, exp_oe});
        if (exp_oe) check(tag, "dout", dout, exp_dout);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    task automatic ld(input logic a_wr_n, input logic [AW-1:0] a, input logic [LANES-1:0] sel);
        tick(1'b0, 1'b0, a_wr_n, a, 3'b010, rnd_word(), sel);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b1, '0, 3'b110, rnd_word(), '0);
    endtask

    initial begin
        burst_il = 1'b0;
        rst_n = 1'b0;
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1, '0, 3'b010, '0, '0);
        rst_n = 1'b1;
        idle(2);
        // R9: advance right after reset issues nothing
        tag = "R9";
        tick(1'b0, 1'b1, 1'b0, 4'd5, 3'b010, rnd_word(), '0);
        idle(2);
        // R3: fill every word with all lanes, then partial writes by pattern
        tag = "R3";
        for (int a = 0; a < DEPTH; a++) ld(1'b0, a[AW-1:0], '0);
        idle(2);
        for (int a = 0; a < DEPTH; a++) ld(1'b0, a[AW-1:0], a[LANES-1:0]);
        idle(2);
        // R2: read every word back to back
        tag = "R2";
        for (int a = 0; a < DEPTH; a++) ld(1'b1, a[AW-1:0], '0);
        idle(2);
        // R10: write, partial write, then reads one and two cycles later
        tag = "R10";
        for (int a = 0; a < DEPTH; a++) begin
            ld(1'b0, a[AW-1:0], '0);
            ld(1'b0, a[AW-1:0], 4'b0101);
            ld(1'b1, a[AW-1:0], '0);
            ld(1'b1, a[AW-1:0], '0);
        end
        idle(2);
        // R7: alternate writes and reads so data slots interleave
        tag = "R7";
        for (int a = 0; a < DEPTH; a++) begin
            ld(1'b0, a[AW-1:0], '0);
            ld(1'b1, a[AW-1:0] ^ 4'd3, '0);
        end
        idle(2);
        // R6: every chip-enable combination on writes, then reads of address 0
        tag = "R6";
        for (int c = 0; c < 8; c++) begin
            tick(1'b0, 1'b0, 1'b0, 4'd0, c[2:0], rnd_word(), '0);
            tick(1'b0, 1'b0, 1'b1, 4'd0, c[2:0], rnd_word(), '0);
            idle(1);
            ld(1'b1, 4'd0, '0);
            idle(1);
        end
        idle(2);
        // R8: bursts from every start, both orders, both types; enables off on advances
        tag = "R8";
        for (int m = 0; m < 2; m++) begin
            burst_il = m[0];
            for (int s = 0; s < 4; s++) begin
                for (int t = 0; t < 2; t++) begin
                    ld(t[0], {2'b10, s[1:0]}, '0);
                    for (int b = 0; b < 3; b++) tick(1'b0, 1'b1, 1'b1, '0, 3'b101, rnd_word(), '0);
                    // R9: a fifth beat is a deselect
                    tick(1'b0, 1'b1, 1'b0, '0, 3'b010, rnd_word(), '0);
                end
                for (int a = 8; a < 12; a++) ld(1'b1, a[AW-1:0], '0);
            end
        end
        idle(2);
        // R9: advance after a deselect load
        tag = "R9";
        ld(1'b0, 4'd6, '0);
        tick(1'b0, 1'b0, 1'b0, 4'd6, 3'b110, rnd_word(), '0);
        tick(1'b0, 1'b1, 1'b0, 4'd6, 3'b010, rnd_word(), '0);
        idle(1);
        ld(1'b1, 4'd6, '0);
        ld(1'b1, 4'd7, '0);
        idle(2);
        // R5: stalls inserted between forwarding-sensitive commands
        tag = "R5";
        for (int a = 0; a < DEPTH; a++) begin
            ld(1'b0, a[AW-1:0], 4'b1010);
            tick(1'b1, 1'b0, 1'b0, a[AW-1:0] ^ 4'd1, 3'b010, rnd_word(), '0);
            ld(1'b1, a[AW-1:0], '0);
            tick(1'b1, 1'b1, 1'b0, '0, 3'b010, rnd_word(), '0);
            tick(1'b1, 1'b0, 1'b1, '0, 3'b010, rnd_word(), '0);
            ld(1'b1, a[AW-1:0], '0);
        end
        idle(2);
        // R4: random mix of all command kinds and stalls
        tag = "R4";
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            burst_il = (i >= 2000);
            tick(k == 0, k == 1 || k == 2, $urandom_range(0, 1) == 1,
                 AW'($urandom), (k == 3) ? 3'($urandom) : 3'b010,
                 rnd_word(), LANES'($urandom));
        end
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule